// File: doc/BRIEF.md
# Divided-Clock Parallel Bus Master

This block lets on-chip logic reach an external device over a narrow parallel bus with a 12-bit halfword address and a 16-bit data path. A requester presents one access at a time with a valid/ready handshake: a byte address, a direction, a size flag (16 or 32 bits) and, for writes, the data. The block turns it into one or two bus cycles. Each cycle raises a frame strobe together with either the read or the write strobe for exactly one bus clock. Reads return their data, zero-extended for a halfword, with a one-cycle response pulse.

The bus runs on a clock produced by a programmable divider of the system clock. The sequencer moves only on the divider's enable, so every spacing on the bus is a whole number of bus clocks. A 32-bit read becomes two halfword reads separated by one idle bus clock. A write that comes after any read waits two extra idle bus clocks. Writes that arrive back to back, including both halves of a 32-bit write, run as an unbroken burst.

Top module: `pbus_master`

## Requirements
- R1: The external halfword address is bits [12:1] of the request byte address, so bit 0 is ignored. The second half of a 32-bit access uses that address plus one, wrapping modulo 4096.
- R2: With a divider setting d of 2 or more, one bus clock lasts d system clocks and the bus clock output has period d. A setting of 0 or 1 makes every system clock a bus clock, and the output then follows the system clock.
- R3: The frame strobe is high exactly when the read or write strobe is high. Each halfword transfer keeps its strobe high for exactly one bus clock.
- R4: A 32-bit read performs the low halfword read first, then one idle bus clock, then the high halfword read.
- R5: Each read request produces exactly one rsp_valid pulse of one system clock. rsp_rdata carries {high,low} for a 32-bit read and {16'h0000,data} for a 16-bit read.
- R6: Read data is taken from bus_din at the end of the bus clock in which the read strobe is high.
- R7: A write that follows a read starts its strobe 3 bus clocks after the read strobe ends. Two of these are turnaround idle, and one is the natural handshake slot.
- R8: A 32-bit write drives the low data half first. A write accepted at the last bus clock of a previous write follows it with no idle bus clock.
- R9: req_ready is high only on a bus clock boundary, and only while the block is idle or in the final bus clock of a write. It is never high during a read strobe. A read that follows a read starts one bus clock after the previous one ends.
- R10: The frame and strobe outputs change only at bus clock boundaries.
- R11: After reset the frame, read and write strobes, rsp_valid and bus_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | 8 | Bus clock divider setting (0 or 1 means no division) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 32 | Write data, low half sent first |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| bus_clk | output | 1 | Divided bus clock |
| bus_frame | output | 1 | Frame strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 12 | Halfword address |
| bus_dout | output | 16 | Write data to device |
| bus_din | input | 16 | Read data from device |

## Verification
Two events can fall on the same bus clock boundary: the end of a write strobe and the acceptance of the next write. When they do, the strobe has to stay high with new address and data and no idle bus clock in between. The bench provokes this by queuing a 16-bit write directly behind a 32-bit write, which wraps the address. It then checks that the three logged write pulses are contiguous and that each lasts exactly one bus clock. The same sweep, run over divider settings 0 to 5, also places the end of a read next to a new request, and checks the one-bus-clock and three-bus-clock spacings computed from the divider.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_STRB = 2'd2,
        ST_GAP  = 2'd3
    } pbus_state_e;

endpackage

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             tick,
    output logic             bus_clk
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             phase;
    } div_t;

    div_t r_q, r_d;
    logic bypass;

    assign bypass = (div_cfg < DIV_W'(2));
    assign tick   = (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (tick) begin
            r_d.cnt = bypass ? '0 : div_cfg - 1'b1;
        end else begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        r_d.phase = (r_d.cnt >= (div_cfg >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Undivided setting forwards the system clock itself.
    assign bus_clk = bypass ? clk : r_q.phase;

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int TURN_IDLE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W:0]     req_addr,
    input  logic [2*DATA_W-1:0] req_wdata,
    output logic                bus_frame,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                cap_en,
    output logic                cap_hi,
    output logic                cap_last
);

    localparam int TC_W = (TURN_IDLE < 2) ? 1 : $clog2(TURN_IDLE + 1);
    localparam int TC_LOAD = (TURN_IDLE > 0) ? TURN_IDLE - 1 : 0;

    typedef struct packed {
        pbus_state_e         state;
        logic                write;
        logic                wide;
        logic                half;
        logic                rd_recent;
        logic [TC_W-1:0]     tcnt;
        logic [ADDR_W-1:0]   addr;
        logic [2*DATA_W-1:0] wdata;
    } seq_t;

    seq_t r_q, r_d;
    logic last;
    logic accept;

    assign last      = !r_q.wide || r_q.half;
    assign req_ready = tick && ((r_q.state == ST_IDLE) ||
                                (r_q.state == ST_STRB && r_q.write && last));
    assign accept    = req_valid && req_ready;

    always_comb begin
        r_d = r_q;
        if (tick) begin
            case (r_q.state)
                ST_TURN: begin
                    if (r_q.tcnt == '0) begin
                        r_d.state = ST_STRB;
                    end else begin
                        r_d.tcnt = r_q.tcnt - 1'b1;
                    end
                end
                ST_STRB: begin
                    if (!last) begin
                        r_d.half  = 1'b1;
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = r_q.write ? ST_STRB : ST_GAP;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.half  = 1'b0;
                        if (!r_q.write) begin
                            r_d.rd_recent = 1'b1;
                        end
                    end
                end
                ST_GAP:  r_d.state = ST_STRB;
                default: r_d.state = ST_IDLE;
            endcase
        end
        if (accept) begin
            r_d.write = req_write;
            r_d.wide  = req_wide;
            r_d.half  = 1'b0;
            r_d.addr  = req_addr[ADDR_W:1];
            r_d.wdata = req_wdata;
            if (req_write) begin
                r_d.rd_recent = 1'b0;
            end
            if (req_write && r_q.rd_recent && (TURN_IDLE > 0)) begin
                r_d.state = ST_TURN;
                r_d.tcnt  = TC_W'(TC_LOAD);
            end else begin
                r_d.state = ST_STRB;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_frame = (r_q.state == ST_STRB);
    assign bus_rd    = bus_frame && !r_q.write;
    assign bus_wr    = bus_frame && r_q.write;
    assign bus_addr  = r_q.addr;
    assign bus_dout  = r_q.half ? r_q.wdata[2*DATA_W-1:DATA_W] : r_q.wdata[DATA_W-1:0];
    assign cap_en    = tick && bus_rd;
    assign cap_hi    = r_q.half;
    assign cap_last  = last;

endmodule

// File: rtl/pbus_rdasm.sv
module pbus_rdasm #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic                cap_hi,
    input  logic                cap_last,
    input  logic [DATA_W-1:0]   bus_din,
    output logic                rsp_valid,
    output logic [2*DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic                valid;
        logic [DATA_W-1:0]   lo;
        logic [2*DATA_W-1:0] data;
    } asm_t;

    asm_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (cap_en) begin
            if (!cap_hi) begin
                r_d.lo = bus_din;
            end
            if (cap_last) begin
                r_d.valid = 1'b1;
                r_d.data  = cap_hi ? {bus_din, r_q.lo} : {{DATA_W{1'b0}}, bus_din};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.valid;
    assign rsp_rdata = r_q.data;

endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int DIV_W     = 8,
    parameter int TURN_IDLE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    div_cfg,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [ADDR_W:0]     req_addr,
    input  logic [2*DATA_W-1:0] req_wdata,
    output logic                rsp_valid,
    output logic [2*DATA_W-1:0] rsp_rdata,
    output logic                bus_clk,
    output logic                bus_frame,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    input  logic [DATA_W-1:0]   bus_din
);

    logic tick_w;
    logic cap_en_w;
    logic cap_hi_w;
    logic cap_last_w;

    pbus_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_cfg (div_cfg),
        .tick    (tick_w),
        .bus_clk (bus_clk)
    );

    pbus_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .TURN_IDLE (TURN_IDLE)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_frame (bus_frame),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .cap_en    (cap_en_w),
        .cap_hi    (cap_hi_w),
        .cap_last  (cap_last_w)
    );

    pbus_rdasm #(.DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en_w),
        .cap_hi    (cap_hi_w),
        .cap_last  (cap_last_w),
        .bus_din   (bus_din),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic req_ready,
    input logic rsp_valid,
    input logic bus_frame,
    input logic bus_rd,
    input logic bus_wr
);

    assert_edge_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable({bus_frame, bus_rd, bus_wr}));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(bus_rd) && !bus_rd));

    assert_not_ready_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !req_ready);

    assert_ready_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> tick);

    assert_no_direct_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd) |-> !bus_wr);

endmodule

bind pbus_master pbus_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_frame (bus_frame),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr)
);

// File: tb/tb_pbus_master.sv
module tb_pbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [12:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_clk, bus_frame, bus_rd, bus_wr;
    logic [11:0] bus_addr;
    logic [15:0] bus_dout, bus_din;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pbus_master dut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_clk(bus_clk), .bus_frame(bus_frame), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    function automatic logic [15:0] dev(input logic [11:0] a);
        return {a[3:0], a} ^ 16'h5A3C;
    endfunction

    // Device answers only while the read strobe is high.
    assign bus_din = bus_rd ? dev(bus_addr) : 16'hDEAD;

    int          st_start [32];
    int          st_len   [32];
    logic        st_wr    [32];
    logic [11:0] st_addr  [32];
    logic [15:0] st_data  [32];
    int          nst = 0;
    logic [31:0] rsp_log  [8];
    int          rsp_cnt = 0;
    int          frame_err = 0;
    int          busy_ready = 0;
    logic        p_act = 1'b0, p_wr = 1'b0;
    logic [11:0] p_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_frame != (bus_rd || bus_wr)) frame_err++;
            if (bus_rd && req_ready) busy_ready++;
            if (bus_rd || bus_wr) begin
                if (!p_act || p_wr != bus_wr || p_addr != bus_addr) begin
                    if (nst < 32) begin
                        st_start[nst] = cyc;
                        st_len[nst]   = 1;
                        st_wr[nst]    = bus_wr;
                        st_addr[nst]  = bus_addr;
                        st_data[nst]  = bus_dout;
                    end
                    nst++;
                end else if (nst > 0 && nst <= 32) begin
                    st_len[nst-1]++;
                end
            end
            p_act  = bus_rd || bus_wr;
            p_wr   = bus_wr;
            p_addr = bus_addr;
            if (rsp_valid) begin
                if (rsp_cnt < 8) rsp_log[rsp_cnt] = rsp_rdata;
                rsp_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input bit wide, input logic [12:0] a, input logic [31:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_wide  = wide;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp();
        while (!rsp_valid) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(bus_frame == 0 && bus_rd == 0 && bus_wr == 0, "R11 strobes", {bus_frame, bus_rd, bus_wr}, 0);
        chk(rsp_valid == 0, "R11 rsp_valid", rsp_valid, 0);
        chk(bus_addr == 0, "R11 bus_addr", bus_addr, 0);

        for (int di = 0; di < 6; di++) begin
            int deff;
            logic [12:0] a1, a2, a3, a4;
            logic [31:0] w, w2;
            deff = (di < 2) ? 1 : di;
            a1 = 13'(100 * di + 6);
            a2 = 13'(13'h0400 + 18 * di);
            a3 = 13'h1FFE;
            a4 = 13'(13'h0155 + 4 * di);
            w  = 32'h9A3C51E0 + 32'(di);
            w2 = 32'h00007E21 + 32'(di);
            div_cfg = 8'(di);
            repeat (20) @(negedge clk);
            nst = 0;
            rsp_cnt = 0;

            issue(1'b0, 1'b0, a1, 32'h0);
            wait_rsp();
            issue(1'b0, 1'b1, a2, 32'h0);
            wait_rsp();
            issue(1'b1, 1'b1, a3, w);
            issue(1'b1, 1'b0, a4, w2);
            repeat (8 * deff + 10) @(negedge clk);

            chk(nst == 6, "R3 pulse count", nst, 6);
            if (nst == 6) begin
                for (int k = 0; k < 6; k++)
                    chk(st_len[k] == deff, "R3 R10 strobe width", st_len[k], deff);
                chk(!st_wr[0] && !st_wr[1] && !st_wr[2] && st_wr[3] && st_wr[4] && st_wr[5],
                    "R3 strobe kinds", {st_wr[0], st_wr[1], st_wr[2], st_wr[3], st_wr[4], st_wr[5]}, 6'b000111);
                chk(st_addr[0] == a1[12:1], "R1 read16 address", st_addr[0], a1[12:1]);
                chk(st_addr[1] == a2[12:1], "R1 R4 low half address", st_addr[1], a2[12:1]);
                chk(st_addr[2] == a2[12:1] + 12'd1, "R1 R4 high half address", st_addr[2], a2[12:1] + 12'd1);
                chk(st_addr[3] == 12'hFFF && st_addr[4] == 12'h000, "R1 wrap address",
                    {st_addr[3], st_addr[4]}, 24'hFFF000);
                chk(st_addr[5] == a4[12:1], "R1 bit0 ignored", st_addr[5], a4[12:1]);
                chk(st_start[1] - (st_start[0] + st_len[0]) == deff, "R9 read-read spacing",
                    st_start[1] - (st_start[0] + st_len[0]), deff);
                chk(st_start[2] - (st_start[1] + st_len[1]) == deff, "R4 idle between halves",
                    st_start[2] - (st_start[1] + st_len[1]), deff);
                chk(st_start[3] - (st_start[2] + st_len[2]) == 3 * deff, "R7 turnaround",
                    st_start[3] - (st_start[2] + st_len[2]), 3 * deff);
                chk(st_start[4] == st_start[3] + st_len[3], "R8 halves contiguous", st_start[4], st_start[3] + st_len[3]);
                chk(st_start[5] == st_start[4] + st_len[4], "R8 write stream", st_start[5], st_start[4] + st_len[4]);
                chk(st_data[3] == w[15:0] && st_data[4] == w[31:16], "R8 write halves order",
                    {st_data[3], st_data[4]}, {w[15:0], w[31:16]});
                chk(st_data[5] == w2[15:0], "R8 write16 data", st_data[5], w2[15:0]);
            end
            chk(rsp_cnt == 2, "R5 response count", rsp_cnt, 2);
            chk(rsp_log[0] == {16'h0000, dev(a1[12:1])}, "R5 R6 read16 data", rsp_log[0], {16'h0000, dev(a1[12:1])});
            chk(rsp_log[1] == {dev(a2[12:1] + 12'd1), dev(a2[12:1])}, "R4 R6 read32 data",
                rsp_log[1], {dev(a2[12:1] + 12'd1), dev(a2[12:1])});
            chk(frame_err == 0, "R3 frame follows strobes", frame_err, 0);
            chk(busy_ready == 0, "R9 ready during read", busy_ready, 0);

            if (di >= 2) begin
                int r1, r2;
                logic p;
                r1 = -1;
                r2 = -1;
                p = bus_clk;
                for (int k = 0; k < 4 * di + 4; k++) begin
                    @(negedge clk);
                    if (bus_clk && !p) begin
                        if (r1 < 0) r1 = cyc;
                        else if (r2 < 0) r2 = cyc;
                    end
                    p = bus_clk;
                end
                chk(r1 >= 0 && r2 - r1 == di, "R2 bus clock period", r2 - r1, di);
            end else begin
                logic lo_s;
                lo_s = bus_clk;
                @(posedge clk);
                #1;
                chk(lo_s == 1'b0 && bus_clk == 1'b1, "R2 undivided clock", {lo_s, bus_clk}, 2'b01);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule